// File: doc/BRIEF.md
# Tick-Driven Sample Sequencer with Byte Link

This block runs one measurement run against a host that sits behind a byte-wide FIFO bridge. After reset it keeps the bridge in reset for a fixed hold time and then releases it. It waits for the bridge's link-up signal to rise. Once the link is up, it reads a one-byte interval code from the host. A valid code clears the external position counters and starts a periodic tick.

On every tick the block captures both position counts as one snapshot. It sends the snapshot to the host as bytes through the bridge's write side. After a fixed number of samples it stops and waits for the next interval code. A tick that arrives while a snapshot is still being sent is dropped, and an overrun flag records it. All three status inputs from the bridge are asynchronous and pass through a synchronizer before the state machine uses them.

Top module: `tick_sample_seq`

## Requirements
- R1: After reset `link_rst_o` is 0 for RST_HOLD clocks and then goes to 1, and it stays at 1 until the next reset.
- R2: No host read (`rd_n_o` low) takes place before a rising edge of `link_up_i` is seen after `link_rst_o` goes high.
- R3: A byte read starts only while `rx_avail_n_i` is low. `rd_n_o` is then low for exactly 4 clocks, and at least 2 idle clocks follow before the next access.
- R4: The interval code selects the tick period: 0x01 selects PERIOD_A, 0x02 selects PERIOD_B and 0x03 selects PERIOD_C clocks. Sample n (counting from 1) holds the counts that were present n×period clocks after the clock in which `clr_o` was high. With a free-running counter cleared by `clr_o`, channel 1 of sample n therefore equals n×period−1.
- R5: A code byte other than 0x01, 0x02 or 0x03 is ignored. It produces no `clr_o`, no write, and the block reads another byte.
- R6: When a valid code is accepted, `clr_o` is high for exactly one clock.
- R7: Each snapshot goes out as 2×POS_W/8 bytes in this order: channel 1 low byte, channel 1 high byte, channel 2 low byte, channel 2 high byte. Each byte is written with a `wr_o` pulse of exactly 4 clocks, during which `bus_o` is stable, and `wr_o` and the read strobe are never active together.
- R8: A run sends exactly NUM_SAMPLES snapshots. After that no further write occurs and the block waits for a new code byte.
- R9: A tick that arrives while a snapshot is still being sent sets `overrun_o` and is skipped, so the next snapshot comes from the following tick. `overrun_o` clears when the next valid code is accepted.
- R10: No write strobe is issued while `tx_space_n_i` is high. The transfer waits until the flag goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos1_i | input | POS_W | Channel 1 position count |
| pos2_i | input | POS_W | Channel 2 position count |
| clr_o | output | 1 | One-clock clear pulse for the position counters |
| link_rst_o | output | 1 | Bridge reset, low holds the bridge disconnected |
| link_up_i | input | 1 | Bridge link status, a rising edge means the host link is up (asynchronous) |
| rx_avail_n_i | input | 1 | Bridge has a byte to read, active low (asynchronous) |
| tx_space_n_i | input | 1 | Bridge can accept a byte, active low (asynchronous) |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_o | output | 1 | Write strobe, active high |
| bus_i | input | 8 | Data from the bridge |
| bus_o | output | 8 | Data to the bridge |
| bus_oe_o | output | 1 | Enable for driving bus_o onto the shared bus |
| overrun_o | output | 1 | A tick was skipped during the current run |

## Verification
A wrong phase in the byte engine shows up on the strobes within one access. The pulse is then not 4 clocks wide, or a read and a write overlap. A wrong tick count or a wrong snapshot shows up in the first transmitted sample, because channel 1 no longer equals n×period−1. This happens within one tick period of the clear pulse. A wrong sample counter or wrong end-of-run handling shows up as a missing or extra write burst within one period of the last expected sample. A wrong overrun path shows up as a sample taken from the wrong tick, or as a flag that stays set into the next run.

// File: rtl/sampseq_pkg.sv
package sampseq_pkg;

   typedef enum logic [2:0] {
      SQ_HOLD,
      SQ_LINK,
      SQ_CODE,
      SQ_CLEAR,
      SQ_ARM,
      SQ_SEND
   } sq_state_t;

   typedef enum logic [1:0] {
      BP_IDLE,
      BP_WAIT,
      BP_STRB,
      BP_GAP
   } bp_phase_t;

   localparam int STROBE_CLKS = 4;
   localparam int GAP_CLKS    = 2;

   localparam logic [7:0] CODE_SLOW = 8'h01;
   localparam logic [7:0] CODE_MID  = 8'h02;
   localparam logic [7:0] CODE_FAST = 8'h03;

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
   parameter int               WIDTH  = 1,
   parameter int               STAGES = 2,
   parameter logic [WIDTH-1:0] INIT   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ss_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= INIT;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= INIT;
            else        r <= g_stage[s-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/ss_tick.sv
module ss_tick #(
   parameter int PERIOD_A = 120000,
   parameter int PERIOD_B = 60000,
   parameter int PERIOD_C = 36000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       stop,
   input  logic [1:0] sel,
   output logic       tick
);

   localparam int PMAX_AB = (PERIOD_A > PERIOD_B) ? PERIOD_A : PERIOD_B;
   localparam int PMAX    = (PMAX_AB > PERIOD_C) ? PMAX_AB : PERIOD_C;
   localparam int CW      = $clog2(PMAX + 1);

   if (PERIOD_A < 2 || PERIOD_B < 2 || PERIOD_C < 2) begin : g_bad_period
      $error("ss_tick: every period must be at least 2 clocks");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lim <= '0;
         en  <= 1'b0;
      end else if (load) begin
         cnt <= '0;
         en  <= 1'b1;
         case (sel)
            2'd1:    lim <= CW'(PERIOD_A - 1);
            2'd2:    lim <= CW'(PERIOD_B - 1);
            default: lim <= CW'(PERIOD_C - 1);
         endcase
      end else if (stop) begin
         en  <= 1'b0;
         cnt <= '0;
      end else if (en) begin
         cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
      end
   end

   assign tick = en && (cnt == lim);

endmodule

// File: rtl/ss_byte_port.sv
module ss_byte_port
   import sampseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_rd,
   input  logic       start_wr,
   input  logic [7:0] wdata,
   input  logic [7:0] bus_in,
   input  logic       avail_n,
   input  logic       space_n,
   output logic       done,
   output logic [7:0] rdata,
   output logic       rd_n,
   output logic       wr,
   output logic [7:0] bus_out,
   output logic       bus_oe
);

   localparam int LMAX = (STROBE_CLKS > GAP_CLKS) ? STROBE_CLKS : GAP_CLKS;
   localparam int CW   = $clog2(LMAX + 1);

   bp_phase_t     phase;
   logic          is_wr;
   logic [CW-1:0] cnt;
   logic [7:0]    wbuf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= BP_IDLE;
         is_wr <= 1'b0;
         cnt   <= '0;
         wbuf  <= '0;
         rdata <= '0;
      end else begin
         case (phase)
            BP_IDLE: begin
               cnt <= '0;
               if (start_wr) begin
                  is_wr <= 1'b1;
                  wbuf  <= wdata;
                  phase <= BP_WAIT;
               end else if (start_rd) begin
                  is_wr <= 1'b0;
                  phase <= BP_WAIT;
               end
            end
            BP_WAIT: begin
               if (is_wr ? !space_n : !avail_n) begin
                  phase <= BP_STRB;
                  cnt   <= '0;
               end
            end
            BP_STRB: begin
               if (cnt == CW'(STROBE_CLKS - 1)) begin
                  if (!is_wr) rdata <= bus_in;
                  phase <= BP_GAP;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == CW'(GAP_CLKS - 1)) begin
                  phase <= BP_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign done    = (phase == BP_GAP) && (cnt == CW'(GAP_CLKS - 1));
   assign rd_n    = !((phase == BP_STRB) && !is_wr);
   assign wr      = (phase == BP_STRB) && is_wr;
   assign bus_out = wbuf;
   assign bus_oe  = is_wr && (phase != BP_IDLE);

endmodule

// File: rtl/tick_sample_seq.sv
module tick_sample_seq
   import sampseq_pkg::*;
#(
   parameter int POS_W       = 16,
   parameter int PERIOD_A    = 120000,
   parameter int PERIOD_B    = 60000,
   parameter int PERIOD_C    = 36000,
   parameter int NUM_SAMPLES = 600,
   parameter int RST_HOLD    = 1200,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] pos1_i,
   input  logic [POS_W-1:0] pos2_i,
   output logic             clr_o,
   output logic             link_rst_o,
   input  logic             link_up_i,
   input  logic             rx_avail_n_i,
   input  logic             tx_space_n_i,
   output logic             rd_n_o,
   output logic             wr_o,
   input  logic [7:0]       bus_i,
   output logic [7:0]       bus_o,
   output logic             bus_oe_o,
   output logic             overrun_o
);

   localparam int NBYTES = (2 * POS_W) / 8;
   localparam int BW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam int SCW    = $clog2(NUM_SAMPLES + 1);
   localparam int HCW    = $clog2(RST_HOLD + 1);

   if (POS_W % 8 != 0 || POS_W < 8) begin : g_bad_posw
      $error("tick_sample_seq: POS_W must be a positive multiple of 8");
   end
   if (NUM_SAMPLES < 1) begin : g_bad_count
      $error("tick_sample_seq: NUM_SAMPLES must be at least 1");
   end
   if (RST_HOLD < 1) begin : g_bad_hold
      $error("tick_sample_seq: RST_HOLD must be at least 1");
   end

   logic rx_n_s, tx_n_s, up_s, up_q;

   ss_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rx_avail_n_i, tx_space_n_i, link_up_i}),
      .q     ({rx_n_s, tx_n_s, up_s})
   );

   sq_state_t          st;
   logic [HCW-1:0]     hold_cnt;
   logic [1:0]         sel_q;
   logic [2*POS_W-1:0] snap;
   logic [BW-1:0]      byte_idx;
   logic [SCW-1:0]     smp_cnt;

   logic       tick, tick_stop;
   logic       bp_done;
   logic [7:0] bp_rdata, bp_wdata;
   logic       code_ok, last_byte, last_smp;

   assign code_ok   = (bp_rdata == CODE_SLOW) || (bp_rdata == CODE_MID) ||
                      (bp_rdata == CODE_FAST);
   assign last_byte = (byte_idx == BW'(NBYTES - 1));
   assign last_smp  = (smp_cnt == SCW'(NUM_SAMPLES - 1));
   assign tick_stop = (st == SQ_SEND) && bp_done && last_byte && last_smp;
   assign bp_wdata  = snap[8*byte_idx +: 8];
   assign clr_o     = (st == SQ_CLEAR);

   ss_tick #(.PERIOD_A(PERIOD_A), .PERIOD_B(PERIOD_B), .PERIOD_C(PERIOD_C)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (st == SQ_CLEAR),
      .stop  (tick_stop),
      .sel   (sel_q),
      .tick  (tick)
   );

   ss_byte_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_rd (st == SQ_CODE),
      .start_wr (st == SQ_SEND),
      .wdata    (bp_wdata),
      .bus_in   (bus_i),
      .avail_n  (rx_n_s),
      .space_n  (tx_n_s),
      .done     (bp_done),
      .rdata    (bp_rdata),
      .rd_n     (rd_n_o),
      .wr       (wr_o),
      .bus_out  (bus_o),
      .bus_oe   (bus_oe_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_HOLD;
         hold_cnt   <= '0;
         link_rst_o <= 1'b0;
         up_q       <= 1'b0;
         sel_q      <= '0;
         snap       <= '0;
         byte_idx   <= '0;
         smp_cnt    <= '0;
         overrun_o  <= 1'b0;
      end else begin
         up_q <= up_s;
         if (tick && st == SQ_SEND) overrun_o <= 1'b1;
         case (st)
            SQ_HOLD: begin
               if (hold_cnt == HCW'(RST_HOLD - 1)) begin
                  link_rst_o <= 1'b1;
                  st         <= SQ_LINK;
               end else begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
            SQ_LINK: if (up_s && !up_q) st <= SQ_CODE;
            SQ_CODE: begin
               if (bp_done && code_ok) begin
                  sel_q <= bp_rdata[1:0];
                  st    <= SQ_CLEAR;
               end
            end
            SQ_CLEAR: begin
               overrun_o <= 1'b0;
               smp_cnt   <= '0;
               st        <= SQ_ARM;
            end
            SQ_ARM: begin
               if (tick) begin
                  snap     <= {pos2_i, pos1_i};
                  byte_idx <= '0;
                  st       <= SQ_SEND;
               end
            end
            default: begin
               if (bp_done) begin
                  if (last_byte) begin
                     smp_cnt <= smp_cnt + 1'b1;
                     st      <= last_smp ? SQ_CODE : SQ_ARM;
                  end else begin
                     byte_idx <= byte_idx + 1'b1;
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/ss_checker.sv
module ss_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_n_o,
   input logic       wr_o,
   input logic [7:0] bus_o,
   input logic       clr_o,
   input logic       link_rst_o
);

   logic [7:0] rd_low, wr_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_low  <= '0;
         wr_high <= '0;
      end else begin
         rd_low  <= !rd_n_o ? rd_low + 1'b1 : '0;
         wr_high <= wr_o ? wr_high + 1'b1 : '0;
      end
   end

   // R3
   rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n_o) |-> rd_low == 8'd4);

   // R7
   wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_o) |-> wr_high == 8'd4);

   // R7
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_o && !rd_n_o));

   // R7
   wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_o && $past(wr_o)) |-> $stable(bus_o));

   // R6
   clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o |=> !clr_o);

   // R1
   link_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_rst_o |=> link_rst_o);

   // R2
   no_read_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_rst_o |-> rd_n_o);

endmodule

bind tick_sample_seq ss_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_n_o     (rd_n_o),
   .wr_o       (wr_o),
   .bus_o      (bus_o),
   .clr_o      (clr_o),
   .link_rst_o (link_rst_o)
);

// File: tb/sim_tick_sample_seq.sv
`timescale 1ns/1ps
module sim_tick_sample_seq;

   localparam int NS    = 4;
   localparam int HOLD  = 20;
   localparam int NB    = NS * 4;
   localparam logic [15:0] MASK = 16'hA5C3;
   // code, period in clocks (scaled values given to the parameters)
   localparam int RUN_TAB [3][2] = '{'{1, 1200}, '{2, 600}, '{3, 360}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] pos = '0;
   logic [15:0] pos1, pos2;
   logic clr, link_rst, link_up, rx_n, tx_n, rd_n, wr, oe, ovr;
   logic [7:0] bus_in, bus_out;

   int tests = 0, fails = 0;
   logic [7:0] wbytes [64];
   int nb = 0, clr_cnt = 0, rd_cnt = 0, bad_width = 0;
   int wr_w = 0, rd_w = 0;
   logic wr_prev = 1'b0, rd_prev = 1'b1;

   always #5 clk = ~clk;

   assign pos1 = pos;
   assign pos2 = pos ^ MASK;

   always @(posedge clk) begin
      if (clr) pos <= '0;
      else     pos <= pos + 16'd1;
   end

   tick_sample_seq #(
      .POS_W(16), .PERIOD_A(1200), .PERIOD_B(600), .PERIOD_C(360),
      .NUM_SAMPLES(NS), .RST_HOLD(HOLD), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pos1_i(pos1), .pos2_i(pos2), .clr_o(clr),
      .link_rst_o(link_rst), .link_up_i(link_up), .rx_avail_n_i(rx_n),
      .tx_space_n_i(tx_n), .rd_n_o(rd_n), .wr_o(wr), .bus_i(bus_in),
      .bus_o(bus_out), .bus_oe_o(oe), .overrun_o(ovr)
   );

   always @(negedge clk) begin
      if (clr) clr_cnt++;
      if (wr && !wr_prev) begin
         if (nb < 64) wbytes[nb] = bus_out;
         nb++;
      end
      if (wr) wr_w++;
      if (!wr && wr_prev) begin
         if (wr_w != 4) bad_width++;
         wr_w = 0;
      end
      if (!rd_n && rd_prev) rd_cnt++;
      if (!rd_n) rd_w++;
      if (rd_n && !rd_prev) begin
         if (rd_w != 4) bad_width++;
         rd_w = 0;
      end
      wr_prev = wr;
      rd_prev = rd_n;
   end

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   task automatic host_send(input logic [7:0] b);
      @(negedge clk);
      bus_in = b;
      rx_n   = 1'b0;
      wait (rd_n == 1'b0);
      wait (rd_n == 1'b1);
      @(negedge clk);
      rx_n = 1'b1;
   endtask

   task automatic wait_bytes(input int n);
      for (int k = 0; k < 20000 && nb < n; k++) @(negedge clk);
   endtask

   task automatic check_samples(input string req, input int period, input int skip_after);
      for (int s = 1; s <= NS; s++) begin
         int tick_no = (skip_after > 0 && s > skip_after) ? s + 1 : s;
         logic [15:0] e1 = 16'(tick_no * period - 1);
         logic [15:0] c1 = {wbytes[4*s-3], wbytes[4*s-4]};
         logic [15:0] c2 = {wbytes[4*s-1], wbytes[4*s-2]};
         check({req, " ch1"}, c1, e1);
         check({req, " ch2"}, c2, e1 ^ MASK);
      end
   endtask

   initial begin
      rx_n = 1'b1; tx_n = 1'b0; link_up = 1'b0; bus_in = 8'h00;
      repeat (5) @(negedge clk);
      // R1 reset state
      check("R1 link_rst at reset", link_rst, 0);
      check("R3 rd_n idle at reset", rd_n, 1);
      check("R7 wr idle at reset", wr, 0);
      check("R9 overrun at reset", ovr, 0);
      check("R6 clr at reset", clr, 0);
      rst_n = 1'b1;
      repeat (HOLD - 5) @(negedge clk);
      check("R1 link_rst held low", link_rst, 0);
      // offer an invalid code before the link is up
      bus_in = 8'h09;
      rx_n   = 1'b0;
      repeat (30) @(negedge clk);
      check("R1 link_rst released", link_rst, 1);
      check("R2 no read before link up", rd_cnt, 0);
      link_up = 1'b1;
      wait (rd_n == 1'b0);
      wait (rd_n == 1'b1);
      @(negedge clk);
      rx_n = 1'b1;
      repeat (300) @(negedge clk);
      // R5 invalid code ignored
      check("R5 invalid code no clear", clr_cnt, 0);
      check("R5 invalid code no write", nb, 0);
      check("R3 one read taken", rd_cnt, 1);
      host_send(8'h00);
      repeat (200) @(negedge clk);
      check("R5 zero code no clear", clr_cnt, 0);

      // table-driven runs
      for (int i = 0; i < 3; i++) begin
         nb = 0; clr_cnt = 0;
         host_send(8'(RUN_TAB[i][0]));
         wait_bytes(NB);
         check("R6 one clear pulse", clr_cnt, 1);
         check_samples("R4 R7", RUN_TAB[i][1], 0);
         repeat (2 * RUN_TAB[i][1]) @(negedge clk);
         check("R8 exact sample count", nb, NB);
      end

      // overrun: stall the write side across a tick
      nb = 0; clr_cnt = 0;
      tx_n = 1'b1;
      host_send(8'h03);
      wait (clr_cnt > 0);
      repeat (800) @(negedge clk);
      check("R10 no write while no space", nb, 0);
      tx_n = 1'b0;
      wait_bytes(NB);
      check("R9 overrun flag set", ovr, 1);
      check_samples("R9 tick skipped", 360, 1);
      repeat (720) @(negedge clk);
      check("R8 overrun run sample count", nb, NB);

      // next run clears the flag
      nb = 0; clr_cnt = 0;
      host_send(8'h01);
      wait (clr_cnt > 0);
      repeat (3) @(negedge clk);
      check("R9 overrun cleared", ovr, 0);
      wait_bytes(NB);
      check_samples("R4 rerun", 1200, 0);
      check("R3 R7 strobe widths", bad_width, 0);
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
   end

endmodule